// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Generator

This block runs one access at a time to an external static memory behind a single chip select. A client posts a read or a write with an address and, for writes, data. The block then plays out a timed access. The chip-select, read-strobe and write-strobe lines each rise and fall at cycle counts taken from compact programmable fields. The access ends with a one-clock done pulse. For reads, the captured data appears on the response bus.

Each timing field uses a short code in which the top bit stands for a large multiple of cycles. This lets long slow-device timings fit into a few bits. The chip select and the active strobe have independent setup and pulse values, and both sit inside one shared cycle length. Writes and reads each have their own full set of fields. An optional wait input from the device can stretch a strobe pulse. After a read, a programmable data-float hold keeps the next access away from the bus until the device has released it. A mode bit selects an 8-bit or a 16-bit data bus.

Top module: `extmem_cs_timer`

## Requirements
- R1: After reset, and at any time no access is running, mem_cs_n, mem_rd_n and mem_wr_n are high (all three lines are active-low), mem_dq_oe is all zero, rsp_done is low, and req_ready is high once no float hold remains.
- R2: Access cycle 0 is the cycle after the request is accepted. A line with a 6-bit setup code s is asserted from access cycle 128*s[5] + s[4:0].
- R3: A 7-bit pulse code p keeps the line asserted for 256*p[6] + p[5:0] cycles after its setup point. The pulse is cut off at the end of the access, and a zero pulse never asserts the line.
- R4: A 9-bit cycle code k gives an access length of L = max(256*k[8:7] + k[6:0], 1) cycles. rsp_done is high for exactly one clock, in access cycle L-1, and the block is idle in the next cycle.
- R5: A write times mem_wr_n and mem_cs_n from the write-strobe and write chip-select fields. A read times mem_rd_n and mem_cs_n from the read-strobe and read chip-select fields. Each set uses its own cycle code.
- R6: Read data is sampled from mem_dq_i at the clock edge where mem_rd_n returns high. It is held on rsp_rdata until the next such edge.
- R7: During a write access, mem_dq_oe is active in every cycle and mem_dq_o carries the request's write data. mem_dq_oe is zero during reads. mem_rd_n and mem_wr_n are never low together.
- R8: When cfg_wait_en is 1 and mem_wait is high in a cycle where the read or write strobe is low, the access counter freezes, so all three lines hold their state. mem_wait has no effect when cfg_wait_en is 0 or when no strobe is low.
- R9: After a read strobe rises, req_ready stays low for cfg_float (0 to 15) cycles with mem_rd_n high, counted from the first cycle after that edge. The next access can begin no earlier than this.
- R10: With cfg_bus16 = 0, only lane 0 (bits 7:0) is used: mem_dq_oe[1] stays 0, mem_dq_o[15:8] is 0 and rsp_rdata[15:8] is captured as 0. With cfg_bus16 = 1, both bytes are used.
- R11: A request is taken only in a cycle where req_valid and req_ready are both high. req_ready is low for the whole access. mem_addr holds the request address through the access.
- R12: All configuration inputs are sampled when the request is accepted. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_strb_setup | input | 6 | Write-strobe setup code |
| cfg_wr_cs_setup | input | 6 | Chip-select setup code for writes |
| cfg_rd_strb_setup | input | 6 | Read-strobe setup code |
| cfg_rd_cs_setup | input | 6 | Chip-select setup code for reads |
| cfg_wr_strb_pulse | input | 7 | Write-strobe pulse code |
| cfg_wr_cs_pulse | input | 7 | Chip-select pulse code for writes |
| cfg_rd_strb_pulse | input | 7 | Read-strobe pulse code |
| cfg_rd_cs_pulse | input | 7 | Chip-select pulse code for reads |
| cfg_wr_cycle | input | 9 | Write access length code |
| cfg_rd_cycle | input | 9 | Read access length code |
| cfg_float | input | 4 | Post-read data-float hold in cycles |
| cfg_bus16 | input | 1 | 1 selects a 16-bit bus, 0 an 8-bit bus |
| cfg_wait_en | input | 1 | Enables pulse stretching by mem_wait |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block can take a request |
| rsp_done | output | 1 | One-clock end-of-access pulse |
| rsp_rdata | output | DATA_W | Last captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_addr | output | ADDR_W | Address to the device |
| mem_dq_o | output | DATA_W | Write data to the device |
| mem_dq_oe | output | DATA_W/8 | Per-byte drive enable |
| mem_dq_i | input | DATA_W | Data from the device |
| mem_wait | input | 1 | Device request to stretch the strobe |

## Verification
The assertions check on every cycle the properties that need no knowledge of the programmed values. Every line is quiet while idle. Read and write strobes are never low together, and there is no drive while reading. The done pulse lasts one clock. The lines freeze while wait stretches a strobe. The upper lane stays off on a narrow bus. The address holds through an access. Only the bench scenarios can show that the decoded codes place each edge in the right cycle, including the large-multiple top bits and the clipping of a long pulse, and that data is taken on the strobe's rising edge. The same scenarios cover the float hold's exact length, and the latching of configuration that changes mid-access.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

    localparam int SETUP_W = 6;
    localparam int PULSE_W = 7;
    localparam int CYCLE_W = 9;
    localparam int FLOAT_W = 4;
    // largest decoded value: cycle 3*256+127 = 895, setup+pulse 159+319 = 478
    localparam int CNT_W   = 10;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] stop;
    } win_t;

    typedef struct packed {
        win_t               cs;
        win_t               strb;
        logic [CNT_W-1:0]   last;
        logic [FLOAT_W-1:0] hold;
    } acc_tm_t;

    // setup: top bit worth 128 cycles
    function automatic logic [CNT_W-1:0] dec_setup(input logic [SETUP_W-1:0] f);
        return (CNT_W'(f[SETUP_W-1]) << 7) + CNT_W'(f[SETUP_W-2:0]);
    endfunction

    // pulse: top bit worth 256 cycles
    function automatic logic [CNT_W-1:0] dec_pulse(input logic [PULSE_W-1:0] f);
        return (CNT_W'(f[PULSE_W-1]) << 8) + CNT_W'(f[PULSE_W-2:0]);
    endfunction

    // cycle: top two bits count units of 256 cycles
    function automatic logic [CNT_W-1:0] dec_cycle(input logic [CYCLE_W-1:0] f);
        return (CNT_W'(f[CYCLE_W-1:CYCLE_W-2]) << 8) + CNT_W'(f[CYCLE_W-3:0]);
    endfunction

endpackage

// File: rtl/extmem_timing_sel.sv
module extmem_timing_sel
    import extmem_pkg::*;
(
    input  logic               op_write,
    input  logic [SETUP_W-1:0] wr_strb_setup,
    input  logic [SETUP_W-1:0] wr_cs_setup,
    input  logic [SETUP_W-1:0] rd_strb_setup,
    input  logic [SETUP_W-1:0] rd_cs_setup,
    input  logic [PULSE_W-1:0] wr_strb_pulse,
    input  logic [PULSE_W-1:0] wr_cs_pulse,
    input  logic [PULSE_W-1:0] rd_strb_pulse,
    input  logic [PULSE_W-1:0] rd_cs_pulse,
    input  logic [CYCLE_W-1:0] wr_cycle,
    input  logic [CYCLE_W-1:0] rd_cycle,
    input  logic [FLOAT_W-1:0] float_cnt,
    output acc_tm_t            tm_o
);

    localparam int NDIR = 2;   // index 0 = read, 1 = write

    logic [SETUP_W-1:0] strb_set [NDIR];
    logic [SETUP_W-1:0] cs_set   [NDIR];
    logic [PULSE_W-1:0] strb_pul [NDIR];
    logic [PULSE_W-1:0] cs_pul   [NDIR];
    logic [CYCLE_W-1:0] cyc_code [NDIR];
    acc_tm_t            dir_tm   [NDIR];

    assign strb_set[0] = rd_strb_setup;
    assign strb_set[1] = wr_strb_setup;
    assign cs_set[0]   = rd_cs_setup;
    assign cs_set[1]   = wr_cs_setup;
    assign strb_pul[0] = rd_strb_pulse;
    assign strb_pul[1] = wr_strb_pulse;
    assign cs_pul[0]   = rd_cs_pulse;
    assign cs_pul[1]   = wr_cs_pulse;
    assign cyc_code[0] = rd_cycle;
    assign cyc_code[1] = wr_cycle;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        logic [CNT_W-1:0] cyc_dec;
        logic [CNT_W-1:0] cs_start;
        logic [CNT_W-1:0] st_start;
        assign cyc_dec  = dec_cycle(cyc_code[g]);
        assign cs_start = dec_setup(cs_set[g]);
        assign st_start = dec_setup(strb_set[g]);
        assign dir_tm[g] = '{
            cs:   '{start: cs_start, stop: cs_start + dec_pulse(cs_pul[g])},
            strb: '{start: st_start, stop: st_start + dec_pulse(strb_pul[g])},
            last: (cyc_dec == '0) ? '0 : cyc_dec - 1'b1,
            hold: float_cnt
        };
    end

    assign tm_o = dir_tm[op_write];

endmodule

// File: rtl/extmem_win.sv
module extmem_win
    import extmem_pkg::*;
(
    input  logic [CNT_W-1:0] cnt_i,
    input  win_t             win_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             on_o
);

    assign on_o = (cnt_i >= win_i.start) && (cnt_i < win_i.stop) && (cnt_i <= last_i);

endmodule

// File: rtl/extmem_cs_timer.sv
module extmem_cs_timer
    import extmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SETUP_W-1:0] cfg_wr_strb_setup,
    input  logic [SETUP_W-1:0] cfg_wr_cs_setup,
    input  logic [SETUP_W-1:0] cfg_rd_strb_setup,
    input  logic [SETUP_W-1:0] cfg_rd_cs_setup,
    input  logic [PULSE_W-1:0] cfg_wr_strb_pulse,
    input  logic [PULSE_W-1:0] cfg_wr_cs_pulse,
    input  logic [PULSE_W-1:0] cfg_rd_strb_pulse,
    input  logic [PULSE_W-1:0] cfg_rd_cs_pulse,
    input  logic [CYCLE_W-1:0] cfg_wr_cycle,
    input  logic [CYCLE_W-1:0] cfg_rd_cycle,
    input  logic [FLOAT_W-1:0] cfg_float,
    input  logic               cfg_bus16,
    input  logic               cfg_wait_en,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_done,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               mem_cs_n,
    output logic               mem_rd_n,
    output logic               mem_wr_n,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_dq_o,
    output logic [DATA_W/8-1:0] mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_i,
    input  logic               mem_wait
);

    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int NWIN   = 2;   // 0 = chip select, 1 = strobe

    typedef struct packed {
        seq_st_e            st;
        logic               wr;
        logic               bus16;
        logic               wait_en;
        acc_tm_t            tm;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic [FLOAT_W-1:0] flt;
    } seq_t;

    seq_t cur_q, nxt_d;

    acc_tm_t           tm_new;
    win_t              win_sel [NWIN];
    logic [NWIN-1:0]   win_hit;
    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] lane_mask;
    logic busy, cs_on, strb_on, stall, at_last, strb_ends, capture, ready;

    extmem_timing_sel u_tsel (
        .op_write      (req_write),
        .wr_strb_setup (cfg_wr_strb_setup),
        .wr_cs_setup   (cfg_wr_cs_setup),
        .rd_strb_setup (cfg_rd_strb_setup),
        .rd_cs_setup   (cfg_rd_cs_setup),
        .wr_strb_pulse (cfg_wr_strb_pulse),
        .wr_cs_pulse   (cfg_wr_cs_pulse),
        .rd_strb_pulse (cfg_rd_strb_pulse),
        .rd_cs_pulse   (cfg_rd_cs_pulse),
        .wr_cycle      (cfg_wr_cycle),
        .rd_cycle      (cfg_rd_cycle),
        .float_cnt     (cfg_float),
        .tm_o          (tm_new)
    );

    assign win_sel[0] = cur_q.tm.cs;
    assign win_sel[1] = cur_q.tm.strb;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        extmem_win u_win (
            .cnt_i  (cur_q.cnt),
            .win_i  (win_sel[g]),
            .last_i (cur_q.tm.last),
            .on_o   (win_hit[g])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_en[l] = (l == 0) ? 1'b1 : cur_q.bus16;
        assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_en[l]}};
        assign mem_dq_oe[l] = busy && cur_q.wr && lane_en[l];
    end

    assign busy      = (cur_q.st == ST_RUN);
    assign cs_on     = busy && win_hit[0];
    assign strb_on   = busy && win_hit[1];
    assign stall     = cur_q.wait_en && mem_wait && strb_on;
    assign at_last   = (cur_q.cnt == cur_q.tm.last);
    assign strb_ends = strb_on && !stall &&
                       ((({1'b0, cur_q.cnt} + 1'b1) == {1'b0, cur_q.tm.strb.stop}) || at_last);
    assign capture   = strb_ends && !cur_q.wr;
    assign ready     = !busy && (cur_q.flt == '0);

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.flt != '0) begin
            nxt_d.flt = cur_q.flt - 1'b1;
        end
        if (!busy) begin
            if (req_valid && ready) begin
                nxt_d.st      = ST_RUN;
                nxt_d.cnt     = '0;
                nxt_d.wr      = req_write;
                nxt_d.bus16   = cfg_bus16;
                nxt_d.wait_en = cfg_wait_en;
                nxt_d.tm      = tm_new;
                nxt_d.addr    = req_addr;
                nxt_d.wdata   = req_wdata;
            end
        end else begin
            if (!stall) begin
                if (at_last) begin
                    nxt_d.st = ST_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            if (capture) begin
                nxt_d.rdata = mem_dq_i & lane_mask;
                nxt_d.flt   = cur_q.tm.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = ready;
    assign rsp_done  = busy && at_last && !stall;
    assign rsp_rdata = cur_q.rdata;
    assign mem_cs_n  = !cs_on;
    assign mem_rd_n  = !(strb_on && !cur_q.wr);
    assign mem_wr_n  = !(strb_on && cur_q.wr);
    assign mem_addr  = cur_q.addr;
    assign mem_dq_o  = cur_q.wdata & lane_mask;

endmodule

// File: rtl/extmem_cs_timer_chk.sv
module extmem_cs_timer_chk #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              wait_en_q,
    input logic              bus16_q,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_cs_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n,
    input logic              mem_wait,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_dq_oe
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && mem_rd_n && mem_wr_n && (mem_dq_oe == '0))); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R4

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !busy); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n)); // R7

    AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_dq_oe == '0)); // R7

    AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wait_en_q && mem_wait && (!mem_rd_n || !mem_wr_n))
        |=> ($stable(mem_cs_n) && $stable(mem_rd_n) && $stable(mem_wr_n))); // R8

    AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus16_q |-> ($countones(mem_dq_oe) <= 1)); // R10

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_rd_n && mem_wr_n)); // R11

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr)); // R11

endmodule

bind extmem_cs_timer extmem_cs_timer_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wait_en_q (cur_q.wait_en),
    .bus16_q   (cur_q.bus16),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_wait  (mem_wait),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/extmem_cs_timer_tb_top.sv
module extmem_cs_timer_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 16;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [5:0]  cfg_wr_strb_setup, cfg_wr_cs_setup, cfg_rd_strb_setup, cfg_rd_cs_setup;
    logic [6:0]  cfg_wr_strb_pulse, cfg_wr_cs_pulse, cfg_rd_strb_pulse, cfg_rd_cs_pulse;
    logic [8:0]  cfg_wr_cycle, cfg_rd_cycle;
    logic [3:0]  cfg_float;
    logic        cfg_bus16, cfg_wait_en;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic        mem_cs_n, mem_rd_n, mem_wr_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o;
    logic [1:0]  mem_dq_oe;
    logic [DW-1:0] mem_dq_i = '0;
    logic        mem_wait = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] model_rdata = '0;

    extmem_cs_timer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_strb_setup(cfg_wr_strb_setup), .cfg_wr_cs_setup(cfg_wr_cs_setup),
        .cfg_rd_strb_setup(cfg_rd_strb_setup), .cfg_rd_cs_setup(cfg_rd_cs_setup),
        .cfg_wr_strb_pulse(cfg_wr_strb_pulse), .cfg_wr_cs_pulse(cfg_wr_cs_pulse),
        .cfg_rd_strb_pulse(cfg_rd_strb_pulse), .cfg_rd_cs_pulse(cfg_rd_cs_pulse),
        .cfg_wr_cycle(cfg_wr_cycle), .cfg_rd_cycle(cfg_rd_cycle),
        .cfg_float(cfg_float), .cfg_bus16(cfg_bus16), .cfg_wait_en(cfg_wait_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int dsetup(input logic [5:0] f);
        return (f[5] ? 128 : 0) + int'(f[4:0]);
    endfunction
    function automatic int dpulse(input logic [6:0] f);
        return (f[6] ? 256 : 0) + int'(f[5:0]);
    endfunction
    function automatic int dcycle(input logic [8:0] f);
        return 256 * int'(f[8:7]) + int'(f[6:0]);
    endfunction
    function automatic bit win_on(input int c, input int s, input int p, input int last);
        return (c >= s) && (c < s + p) && (c <= last);
    endfunction
    function automatic logic [DW-1:0] lane_mask(input bit b16);
        return b16 ? 16'hFFFF : 16'h00FF;
    endfunction

    task automatic set_typical();
        cfg_wr_strb_setup = 6'd1; cfg_wr_strb_pulse = 7'd4;
        cfg_wr_cs_setup   = 6'd0; cfg_wr_cs_pulse   = 7'd3;
        cfg_rd_strb_setup = 6'd1; cfg_rd_strb_pulse = 7'd3;
        cfg_rd_cs_setup   = 6'd0; cfg_rd_cs_pulse   = 7'd2;
        cfg_wr_cycle = 9'd7; cfg_rd_cycle = 9'd4;
        cfg_float = 4'd3; cfg_bus16 = 1'b0; cfg_wait_en = 1'b0;
    endtask

    task automatic rand_cfg();
        cfg_wr_strb_setup = 6'($urandom % 8); cfg_wr_cs_setup = 6'($urandom % 8);
        cfg_rd_strb_setup = 6'($urandom % 8); cfg_rd_cs_setup = 6'($urandom % 8);
        cfg_wait_en = 1'($urandom % 2);
        cfg_wr_strb_pulse = 7'(($urandom % 8) + (cfg_wait_en ? 1 : 0));
        cfg_wr_cs_pulse   = 7'(($urandom % 8) + (cfg_wait_en ? 1 : 0));
        cfg_rd_strb_pulse = 7'(($urandom % 8) + (cfg_wait_en ? 1 : 0));
        cfg_rd_cs_pulse   = 7'(($urandom % 8) + (cfg_wait_en ? 1 : 0));
        cfg_wr_cycle = 9'($urandom % 21);
        cfg_rd_cycle = 9'($urandom % 21);
        cfg_float = 4'($urandom % 16);
        cfg_bus16 = 1'($urandom % 2);
    endtask

    task automatic run_access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                              input int wait_pct, input bit scramble);
        int ss, sp, css, csp, cyc, last, fl, c, cap_c, guard, j, exp_j;
        bit b16, wen, w, stall, e_cs, e_st, e_done, captured;
        real cap_t;
        logic [DW-1:0] din;
        logic [75:0] saved;
        saved = {cfg_wr_strb_setup, cfg_wr_cs_setup, cfg_rd_strb_setup, cfg_rd_cs_setup,
                 cfg_wr_strb_pulse, cfg_wr_cs_pulse, cfg_rd_strb_pulse, cfg_rd_cs_pulse,
                 cfg_wr_cycle, cfg_rd_cycle, cfg_float, cfg_bus16, cfg_wait_en};
        ss  = wr ? dsetup(cfg_wr_strb_setup) : dsetup(cfg_rd_strb_setup);
        sp  = wr ? dpulse(cfg_wr_strb_pulse) : dpulse(cfg_rd_strb_pulse);
        css = wr ? dsetup(cfg_wr_cs_setup)   : dsetup(cfg_rd_cs_setup);
        csp = wr ? dpulse(cfg_wr_cs_pulse)   : dpulse(cfg_rd_cs_pulse);
        cyc = wr ? dcycle(cfg_wr_cycle)      : dcycle(cfg_rd_cycle);
        last = (cyc == 0) ? 0 : cyc - 1;
        fl = int'(cfg_float); b16 = cfg_bus16; wen = cfg_wait_en;
        captured = 1'b0; cap_c = 0; cap_t = 0.0;

        @(negedge clk); mem_wait = 1'b0; #1;
        guard = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk); #1; guard++;
        end
        chk(req_ready && mem_cs_n && mem_rd_n && mem_wr_n && mem_dq_oe == 2'b00,
            "R1 idle lines quiet before request", int'(mem_dq_oe), 0);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin
            {cfg_wr_strb_setup, cfg_wr_cs_setup, cfg_rd_strb_setup, cfg_rd_cs_setup} = 24'($urandom);
            {cfg_wr_strb_pulse, cfg_wr_cs_pulse, cfg_rd_strb_pulse, cfg_rd_cs_pulse} = 28'($urandom);
            {cfg_wr_cycle, cfg_rd_cycle, cfg_float, cfg_bus16, cfg_wait_en} = 24'($urandom);
        end
        c = 0;
        forever begin
            w = (int'($urandom % 100) < wait_pct);
            mem_wait = w;
            din = DW'($urandom);
            mem_dq_i = din;
            #1;
            e_cs = win_on(c, css, csp, last);
            e_st = win_on(c, ss, sp, last);
            chk(mem_cs_n == !e_cs, scramble ? "R12 cs latched" : "R2 R3 R5 chip select timing",
                int'(mem_cs_n), int'(!e_cs));
            chk(mem_rd_n == !(e_st && !wr), "R2 R3 R5 read strobe timing", int'(mem_rd_n), int'(!(e_st && !wr)));
            chk(mem_wr_n == !(e_st && wr), "R2 R3 R5 write strobe timing", int'(mem_wr_n), int'(!(e_st && wr)));
            chk(mem_dq_oe == (wr ? (b16 ? 2'b11 : 2'b01) : 2'b00), "R7 R10 drive enable",
                int'(mem_dq_oe), int'(wr ? (b16 ? 2'b11 : 2'b01) : 2'b00));
            if (wr) chk(mem_dq_o == (d & lane_mask(b16)), "R7 R10 write data", int'(mem_dq_o), int'(d & lane_mask(b16)));
            chk(mem_addr == a && !req_ready, "R11 address held, not ready", int'(mem_addr), int'(a));
            stall = wen && w && e_st;
            if (!wr && e_st && !stall && ((c + 1 == ss + sp) || (c == last))) begin
                model_rdata = din & lane_mask(b16);
                captured = 1'b1; cap_c = c; cap_t = $realtime;
            end
            e_done = (c == last) && !stall;
            chk(rsp_done == e_done, "R4 R8 done timing", int'(rsp_done), int'(e_done));
            if (e_done || c > 2000) break;
            if (!stall) c++;
            @(negedge clk);
        end
        if (scramble) begin
            {cfg_wr_strb_setup, cfg_wr_cs_setup, cfg_rd_strb_setup, cfg_rd_cs_setup,
             cfg_wr_strb_pulse, cfg_wr_cs_pulse, cfg_rd_strb_pulse, cfg_rd_cs_pulse,
             cfg_wr_cycle, cfg_rd_cycle, cfg_float, cfg_bus16, cfg_wait_en} = saved;
        end
        @(negedge clk); mem_wait = 1'b0; #1;
        chk(!rsp_done && mem_cs_n && mem_rd_n && mem_wr_n, "R4 idle after done", int'(rsp_done), 0);
        if (!wr) begin
            chk(rsp_rdata == model_rdata, "R6 R10 read data", int'(rsp_rdata), int'(model_rdata));
            if (captured) begin
                exp_j = (fl + 1 > last - cap_c + 1) ? fl + 1 : last - cap_c + 1;
                guard = 0;
                while (!req_ready && guard < 40) begin
                    @(negedge clk); #1; guard++;
                end
                j = int'(($realtime - cap_t) / 5.0);
                chk(j == exp_j, "R9 float hold length", j, exp_j);
            end else begin
                chk(req_ready == 1'b1, "R9 no hold without strobe", int'(req_ready), 1);
            end
        end else begin
            chk(req_ready == 1'b1, "R11 ready after write", int'(req_ready), 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        set_typical();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(mem_cs_n && mem_rd_n && mem_wr_n, "R1 reset lines high", int'({mem_cs_n, mem_rd_n, mem_wr_n}), 7);
        chk(mem_dq_oe == 2'b00 && !rsp_done, "R1 reset no drive", int'(mem_dq_oe), 0);
        chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);

        // typical programming, narrow bus, back-to-back reads exercise the float hold (R9)
        run_access(1'b1, 16'h1234, 16'hA55A, 0, 1'b0);
        run_access(1'b0, 16'h1234, 16'h0000, 0, 1'b0);
        run_access(1'b0, 16'h0042, 16'h0000, 0, 1'b0);

        // wide bus (R10)
        cfg_bus16 = 1'b1;
        run_access(1'b1, 16'hBEEF, 16'hC3D2, 0, 1'b0);
        run_access(1'b0, 16'hBEEF, 16'h0000, 0, 1'b0);

        // large-multiple top bits (R2 R3 R4)
        cfg_rd_strb_setup = 6'h21; cfg_rd_strb_pulse = 7'h41;
        cfg_rd_cs_setup   = 6'h20; cfg_rd_cs_pulse   = 7'h40;
        cfg_rd_cycle = 9'h183;
        run_access(1'b0, 16'h0777, 16'h0000, 0, 1'b0);
        cfg_wr_strb_setup = 6'h20; cfg_wr_strb_pulse = 7'h40; cfg_wr_cycle = 9'h090;
        run_access(1'b1, 16'h0778, 16'h9ABC, 0, 1'b0);

        // strobe clipped by cycle end, float 15 (R3 R9)
        set_typical();
        cfg_rd_strb_setup = 6'd2; cfg_rd_strb_pulse = 7'd10; cfg_rd_cycle = 9'd5; cfg_float = 4'd15;
        run_access(1'b0, 16'h0005, 16'h0000, 0, 1'b0);
        cfg_float = 4'd0;
        run_access(1'b0, 16'h0006, 16'h0000, 0, 1'b0);

        // zero cycle code gives a one-cycle access (R4)
        cfg_wr_cycle = 9'd0; cfg_wr_strb_setup = 6'd0; cfg_wr_strb_pulse = 7'd1;
        run_access(1'b1, 16'h0001, 16'h00FF, 0, 1'b0);

        // wait enabled stretches; wait disabled is ignored (R8)
        set_typical();
        cfg_wait_en = 1'b1;
        run_access(1'b0, 16'h0100, 16'h0000, 60, 1'b0);
        run_access(1'b1, 16'h0101, 16'h1357, 60, 1'b0);
        cfg_wait_en = 1'b0;
        run_access(1'b0, 16'h0102, 16'h0000, 100, 1'b0);
        run_access(1'b1, 16'h0103, 16'h2468, 100, 1'b0);

        // configuration changed mid-access (R12)
        set_typical();
        run_access(1'b1, 16'h0200, 16'h5AA5, 0, 1'b1);
        run_access(1'b0, 16'h0201, 16'h0000, 0, 1'b1);

        // constrained random
        for (int i = 0; i < 150; i++) begin
            rand_cfg();
            run_access(1'($urandom % 2), AW'($urandom), DW'($urandom), int'($urandom % 70), 1'($urandom % 4 == 0));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule